// File: doc/BRIEF.md
# Key-Gated One-Time Fuse Controller

This block is a register-mapped controller for a bank of one-time-programmable fuse words, modelled here as internal flops. Software programs a word with two bus writes: an unlock code to the key register, then the value to the target fuse word. The second write starts a burn that lasts a fixed, parameterised number of cycles. At the end of the burn the new bits are merged into the stored word. Fuses can only ever go from 0 to 1.

Completion and failure are reported as two separate sticky status bits. A status read clears them. Each bit can drive the interrupt line through its own enable. A sticky mask control in the mode register hides the fuse contents from bus reads until the next reset. The top fuse word is decoded onto three dedicated configuration outputs, which a neighbouring block consumes and which the mask does not affect. A test input forces a burn to fail so that the error path can be exercised.

Top module: `otp_keyed_ctrl`

## Requirements
- R1: After reset every fuse word, the status bits, the interrupt enables and the mask are 0, and `irq`, `bus_rdata` and the configuration outputs are 0.
- R2: Register map, decoded from 32-bit aligned byte addresses:
  - 0x00: key, reads 0.
  - 0x04: mode, bit 0 is the mask.
  - 0x10: interrupt enable.
  - 0x14: interrupt disable.
  - 0x18: interrupt enable readback.
  - 0x1C: status, bit 0 done and bit 1 fail.
  - 0x20 + 4·n: fuse word n, for n from 0 to NUM_WORDS-1.

  Any other address reads 0. `bus_rdata` takes the read value at the clock edge where `bus_re` is sampled high.
- R3: A fuse word write starts a burn only when the most recent earlier bus write was 0x000000FB to the key register. Every bus write consumes the key; a bus read does not. A fuse write without a valid key leaves the fuses unchanged and sets the fail bit.
- R4: A burn started at edge E merges into the fuse word at edge E+BURN_CYCLES. A read sampled at that same edge still returns the old value. The done bit is cleared at E and set at E+BURN_CYCLES.
- R5: After a burn, the stored word is the bitwise OR of its old contents and the written value; bits are never cleared.
- R6: A fuse write made while a burn is in progress is rejected: it sets the fail bit, changes no fuse word and leaves the running burn intact.
- R7: If `inject_fail` is high at the final edge of a burn, the fuse word is left unchanged and both the done and fail bits are set.
- R8: Writing 1 to mode bit 0 sets the mask. The mask stays set until reset, and writing 0 does not clear it. While the mask is set, fuse word reads return 0 and mode reads return 1.
- R9: A status read returns the current done and fail bits and clears both of them.
- R10: Writing 1s to the enable or disable register sets or clears the matching enable bits (bit 0 done, bit 1 fail). `irq` is high while an enabled status bit is set.
- R11: The top fuse word drives the configuration outputs, whatever the mask: bits 29:0 go to `cfg_boot`, bit 30 to `cfg_jtag_off` and bit 31 to `cfg_secure_dbg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| inject_fail | input | 1 | Forces the burn that ends this cycle to fail |
| irq | output | 1 | Interrupt, enabled status bits ORed |
| cfg_boot | output | BOOT_W | Boot configuration field of the top fuse word |
| cfg_jtag_off | output | 1 | Debug-port disable fuse |
| cfg_secure_dbg | output | 1 | Secure-debug fuse |

## Verification
Read data is due one edge after `bus_re` is sampled, and status and `irq` change at the same edge as the write or burn end that causes them. A fuse update lands exactly BURN_CYCLES edges after the data write edge. The bench drives all inputs on falling edges and counts falling edges from the write. It reads once at the commit edge, expecting the old value, and once at the edge after it, expecting the new one. Every other result is sampled at the falling edge that follows the edge on which it is due.

// File: rtl/otp_pkg.sv
package otp_pkg;
  // byte offsets of the control registers
  localparam int OFF_KEY   = 'h00;
  localparam int OFF_MODE  = 'h04;
  localparam int OFF_IEN   = 'h10;
  localparam int OFF_IDIS  = 'h14;
  localparam int OFF_IMR   = 'h18;
  localparam int OFF_STAT  = 'h1C;
  localparam int OFF_FUSE0 = 'h20;
  // status / interrupt bit positions
  localparam int ST_DONE = 0;
  localparam int ST_FAIL = 1;
  localparam int ST_W    = 2;
endpackage

// File: rtl/otp_key_gate.sv
module otp_key_gate #(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] KEY_CODE = 32'h0000_00FB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_any,
  input  logic              wr_key,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);
  // every bus write re-evaluates the key; only a matching key write arms it
  always_ff @(posedge clk) begin
    if (rst)         armed <= 1'b0;
    else if (wr_any) armed <= wr_key && (wdata == DATA_W'(KEY_CODE));
  end
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq #(
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 5,
  parameter int BURN_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [DATA_W-1:0] start_val,
  input  logic              inject_fail,
  output logic              busy,
  output logic              finish,
  output logic              commit,
  output logic [IDX_W-1:0]  burn_idx,
  output logic [DATA_W-1:0] burn_val
);
  localparam int CNT_W = (BURN_CYCLES > 1) ? $clog2(BURN_CYCLES) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      burn_idx <= '0;
      burn_val <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= CNT_W'(BURN_CYCLES - 1);
      burn_idx <= start_idx;
      burn_val <= start_val;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign finish = busy && (cnt == '0);
  assign commit = finish && !inject_fail;
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 17,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [DATA_W-1:0] set_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] top_word
);
  logic [DATA_W-1:0] mem [NUM_WORDS];

  // bits can only be added: OR the burn value into the addressed word
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_WORDS; w++) mem[w] <= '0;
    end else if (set_en) begin
      mem[set_idx] <= mem[set_idx] | set_val;
    end
  end

  assign rd_word  = (int'(rd_idx) < NUM_WORDS) ? mem[rd_idx] : '0;
  assign top_word = mem[NUM_WORDS-1];
endmodule

// File: rtl/otp_keyed_ctrl.sv
module otp_keyed_ctrl
  import otp_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          NUM_WORDS   = 17,
  parameter int          BURN_CYCLES = 16,
  parameter int          BOOT_W      = 30,
  parameter logic [31:0] KEY_CODE    = 32'h0000_00FB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              inject_fail,
  output logic              irq,
  output logic [BOOT_W-1:0] cfg_boot,
  output logic              cfg_jtag_off,
  output logic              cfg_secure_dbg
);
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int WA_W      = ADDR_W - 2;
  localparam int FUSE_BASE = OFF_FUSE0 / 4;

  // ---------------- address decode ----------------
  logic            aligned;
  logic [WA_W-1:0] waddr;
  logic            hit_key, hit_mode, hit_ien, hit_idis, hit_imr, hit_stat, hit_fuse;
  logic [IDX_W-1:0] fuse_idx;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign waddr    = bus_addr[ADDR_W-1:2];
  assign hit_key  = aligned && (int'(waddr) == OFF_KEY / 4);
  assign hit_mode = aligned && (int'(waddr) == OFF_MODE / 4);
  assign hit_ien  = aligned && (int'(waddr) == OFF_IEN / 4);
  assign hit_idis = aligned && (int'(waddr) == OFF_IDIS / 4);
  assign hit_imr  = aligned && (int'(waddr) == OFF_IMR / 4);
  assign hit_stat = aligned && (int'(waddr) == OFF_STAT / 4);
  assign hit_fuse = aligned && (int'(waddr) >= FUSE_BASE) &&
                    (int'(waddr) < FUSE_BASE + NUM_WORDS);
  assign fuse_idx = IDX_W'(int'(waddr) - FUSE_BASE);

  // ---------------- key and burn ----------------
  logic              key_armed;
  logic              busy, finish, commit;
  logic [IDX_W-1:0]  burn_idx;
  logic [DATA_W-1:0] burn_val;
  logic              data_wr, burn_start, reject, stat_rd;

  assign data_wr    = bus_we && hit_fuse;
  assign burn_start = data_wr && key_armed && !busy;
  assign reject     = data_wr && !burn_start;
  assign stat_rd    = bus_re && hit_stat;

  otp_key_gate #(
    .DATA_W   (DATA_W),
    .KEY_CODE (KEY_CODE)
  ) u_key (
    .clk    (clk),
    .rst    (rst),
    .wr_any (bus_we),
    .wr_key (hit_key),
    .wdata  (bus_wdata),
    .armed  (key_armed)
  );

  otp_burn_seq #(
    .DATA_W      (DATA_W),
    .IDX_W       (IDX_W),
    .BURN_CYCLES (BURN_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (burn_start),
    .start_idx   (fuse_idx),
    .start_val   (bus_wdata),
    .inject_fail (inject_fail),
    .busy        (busy),
    .finish      (finish),
    .commit      (commit),
    .burn_idx    (burn_idx),
    .burn_val    (burn_val)
  );

  logic [DATA_W-1:0] rd_word, top_word;

  otp_fuse_array #(
    .DATA_W    (DATA_W),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
  ) u_arr (
    .clk      (clk),
    .rst      (rst),
    .set_en   (commit),
    .set_idx  (burn_idx),
    .set_val  (burn_val),
    .rd_idx   (fuse_idx),
    .rd_word  (rd_word),
    .top_word (top_word)
  );

  // ---------------- control state ----------------
  logic            st_done, st_fail, mask_q;
  logic [ST_W-1:0] imr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_done <= 1'b0;
      st_fail <= 1'b0;
      mask_q  <= 1'b0;
      imr     <= '0;
    end else begin
      // read-to-clear first, so that setting events in the same cycle win
      if (stat_rd) begin
        st_done <= 1'b0;
        st_fail <= 1'b0;
      end
      if (burn_start)                     st_done <= 1'b0;
      if (finish)                         st_done <= 1'b1;
      if ((finish && inject_fail) || reject) st_fail <= 1'b1;
      if (bus_we && hit_mode) mask_q <= mask_q | bus_wdata[0];
      if (bus_we && hit_ien)  imr    <= imr | bus_wdata[ST_W-1:0];
      if (bus_we && hit_idis) imr    <= imr & ~bus_wdata[ST_W-1:0];
    end
  end

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (hit_mode) begin
      rd_mux[0] = mask_q;
    end else if (hit_imr) begin
      rd_mux[ST_W-1:0] = imr;
    end else if (hit_stat) begin
      rd_mux[ST_DONE] = st_done;
      rd_mux[ST_FAIL] = st_fail;
    end else if (hit_fuse && !mask_q) begin
      rd_mux = rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign irq            = (st_done && imr[ST_DONE]) || (st_fail && imr[ST_FAIL]);
  assign cfg_boot       = top_word[BOOT_W-1:0];
  assign cfg_jtag_off   = top_word[BOOT_W];
  assign cfg_secure_dbg = top_word[BOOT_W+1];
endmodule

// File: rtl/otp_keyed_ctrl_chk.sv
module otp_keyed_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int BOOT_W = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              data_wr,
  input logic              key_armed,
  input logic              busy,
  input logic              st_done,
  input logic              st_fail,
  input logic              mask_q,
  input logic              bus_re,
  input logic              hit_fuse,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [BOOT_W-1:0] cfg_boot,
  input logic              cfg_jtag_off,
  input logic              cfg_secure_dbg
);
  // R3: a fuse write without the key is flagged as failed
  a_r3_nokey_fails: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !key_armed) |=> st_fail);

  // R6: a fuse write during a burn is flagged as failed
  a_r6_busy_write_fails: assert property (@(posedge clk) disable iff (rst)
    (data_wr && busy) |=> st_fail);

  // R4: done is low when a burn begins
  a_r4_done_low_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !st_done);

  // R8: the mask never drops without reset
  a_r8_mask_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(mask_q) |-> mask_q);

  // R8: masked fuse reads return zero
  a_r8_masked_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && hit_fuse && mask_q) |=> (bus_rdata == '0));

  // R5: configuration fuses only ever gain bits
  a_r5_cfg_only_rise: assert property (@(posedge clk) disable iff (rst)
    ((($past(cfg_boot) & ~cfg_boot) == '0) &&
     (!$past(cfg_jtag_off) || cfg_jtag_off) &&
     (!$past(cfg_secure_dbg) || cfg_secure_dbg)));
endmodule

bind otp_keyed_ctrl otp_keyed_ctrl_chk #(
  .DATA_W (DATA_W),
  .BOOT_W (BOOT_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .data_wr        (data_wr),
  .key_armed      (key_armed),
  .busy           (busy),
  .st_done        (st_done),
  .st_fail        (st_fail),
  .mask_q         (mask_q),
  .bus_re         (bus_re),
  .hit_fuse       (hit_fuse),
  .bus_rdata      (bus_rdata),
  .cfg_boot       (cfg_boot),
  .cfg_jtag_off   (cfg_jtag_off),
  .cfg_secure_dbg (cfg_secure_dbg)
);

// File: tb/otp_keyed_ctrl_tb.sv
module otp_keyed_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW         = 17;
  localparam int BURN       = 5;
  localparam int WDOG       = 200000;

  localparam logic [7:0] A_KEY  = 8'h00;
  localparam logic [7:0] A_MODE = 8'h04;
  localparam logic [7:0] A_IEN  = 8'h10;
  localparam logic [7:0] A_IDIS = 8'h14;
  localparam logic [7:0] A_IMR  = 8'h18;
  localparam logic [7:0] A_STAT = 8'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        inject_fail = 1'b0;
  logic        irq;
  logic [29:0] cfg_boot;
  logic        cfg_jtag_off, cfg_secure_dbg;

  int n_checks = 0;
  int n_err    = 0;
  logic [31:0] model [NW];
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_keyed_ctrl #(.BURN_CYCLES(BURN)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .inject_fail(inject_fail), .irq(irq), .cfg_boot(cfg_boot),
    .cfg_jtag_off(cfg_jtag_off), .cfg_secure_dbg(cfg_secure_dbg)
  );

  function automatic logic [7:0] fa(input int w);
    return 8'(32 + 4 * w);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic burn(input int w, input logic [31:0] d);
    bus_write(A_KEY, 32'h0000_00FB);
    bus_write(fa(w), d);
    repeat (BURN + 1) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 cfg", {cfg_secure_dbg, cfg_jtag_off, cfg_boot}, 32'h0);
    bus_read(A_STAT, v); check("R1 status", v, 32'h0);
    bus_read(A_IMR, v);  check("R1 imr", v, 32'h0);
    bus_read(A_MODE, v); check("R1 mode", v, 32'h0);
    bus_read(fa(NW-1), v); check("R1 fuse top", v, 32'h0);
    // R2 key and reserved addresses read zero
    bus_read(A_KEY, v);  check("R2 key reads 0", v, 32'h0);
    bus_read(8'h08, v);  check("R2 reserved", v, 32'h0);
    bus_read(8'h64, v);  check("R2 past last word", v, 32'h0);

    // R2/R4/R5/R9 sweep: two passes over every word
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < NW; w++) begin
        logic [31:0] pat;
        pat = 32'h1 << (w + 8 * p);
        model[w] = model[w] | pat;
        burn(w, pat);
        bus_read(A_STAT, v); check("R4 done after burn", v, 32'h1);
        bus_read(A_STAT, v); check("R9 status cleared", v, 32'h0);
        bus_read(fa(w), v);  check("R5 word OR", v, model[w]);
      end
    end
    check("R11 cfg_boot", {2'b00, cfg_boot}, {2'b00, model[NW-1][29:0]});

    // R4 exact commit edge
    bus_write(A_KEY, 32'h0000_00FB);
    bus_write(fa(0), 32'h8000_0000);
    repeat (BURN - 1) @(negedge clk);
    bus_read(fa(0), v); check("R4 old at commit edge", v, model[0]);
    model[0] = model[0] | 32'h8000_0000;
    bus_read(fa(0), v); check("R4 new after commit", v, model[0]);
    bus_read(A_STAT, v); check("R4 done", v, 32'h1);

    // R3 no key
    bus_write(fa(4), 32'h0000_0F00);
    repeat (BURN + 1) @(negedge clk);
    bus_read(A_STAT, v); check("R3 nokey fail", v, 32'h2);
    bus_read(fa(4), v);  check("R3 nokey unchanged", v, model[4]);
    // R3 wrong key
    bus_write(A_KEY, 32'h0000_00FC);
    bus_write(fa(4), 32'h0000_0F00);
    repeat (BURN + 1) @(negedge clk);
    bus_read(A_STAT, v); check("R3 wrong key fail", v, 32'h2);
    bus_read(fa(4), v);  check("R3 wrong key unchanged", v, model[4]);
    // R3 key consumed by another write
    bus_write(A_KEY, 32'h0000_00FB);
    bus_write(A_IEN, 32'h0);
    bus_write(fa(4), 32'h0000_0F00);
    repeat (BURN + 1) @(negedge clk);
    bus_read(A_STAT, v); check("R3 consumed key fail", v, 32'h2);
    bus_read(fa(4), v);  check("R3 consumed key unchanged", v, model[4]);
    // R3 a read does not consume the key
    bus_write(A_KEY, 32'h0000_00FB);
    bus_read(A_MODE, v);
    bus_write(fa(4), 32'h0000_0F00);
    model[4] = model[4] | 32'h0000_0F00;
    repeat (BURN + 1) @(negedge clk);
    bus_read(A_STAT, v); check("R3 read keeps key", v, 32'h1);
    bus_read(fa(4), v);  check("R3 read keeps key word", v, model[4]);

    // R4/R6 write during a burn
    burn(1, 32'h4000_0000);
    model[1] = model[1] | 32'h4000_0000;
    bus_write(A_KEY, 32'h0000_00FB);
    bus_write(fa(2), 32'h0030_0000);
    model[2] = model[2] | 32'h0030_0000;
    bus_read(A_STAT, v); check("R4 done cleared at start", v, 32'h0);
    bus_write(A_KEY, 32'h0000_00FB);
    bus_write(fa(3), 32'h0C00_0000);
    bus_read(A_STAT, v); check("R6 busy write fail", v, 32'h2);
    repeat (BURN + 1) @(negedge clk);
    bus_read(A_STAT, v); check("R6 running burn done", v, 32'h1);
    bus_read(fa(2), v);  check("R6 running burn word", v, model[2]);
    bus_read(fa(3), v);  check("R6 rejected word", v, model[3]);

    // R7 injected failure
    inject_fail = 1'b1;
    burn(5, 32'h00F0_0000);
    inject_fail = 1'b0;
    bus_read(A_STAT, v); check("R7 done and fail", v, 32'h3);
    bus_read(fa(5), v);  check("R7 word unchanged", v, model[5]);

    // R10 interrupts
    bus_write(A_IEN, 32'h1);
    bus_read(A_IMR, v); check("R10 imr set", v, 32'h1);
    burn(6, 32'h0001_0000);
    model[6] = model[6] | 32'h0001_0000;
    check("R10 irq on done", {31'h0, irq}, 32'h1);
    bus_write(A_IDIS, 32'h1);
    check("R10 irq disabled", {31'h0, irq}, 32'h0);
    bus_read(A_IMR, v); check("R10 imr cleared", v, 32'h0);
    bus_write(A_IEN, 32'h2);
    check("R10 done not enabled", {31'h0, irq}, 32'h0);
    bus_write(fa(6), 32'h1);
    check("R10 irq on fail", {31'h0, irq}, 32'h1);
    bus_read(A_STAT, v); check("R9 status value", v, 32'h3);
    check("R9 irq after clear", {31'h0, irq}, 32'h0);

    // R11 top word decode
    burn(NW-1, 32'hC000_0000);
    model[NW-1] = model[NW-1] | 32'hC000_0000;
    check("R11 cfg outputs", {cfg_secure_dbg, cfg_jtag_off, cfg_boot}, model[NW-1]);

    // R8 mask
    bus_write(A_MODE, 32'h1);
    bus_read(A_MODE, v);  check("R8 mode set", v, 32'h1);
    bus_read(fa(0), v);   check("R8 masked read", v, 32'h0);
    bus_write(A_MODE, 32'h0);
    bus_read(A_MODE, v);  check("R8 mask sticky", v, 32'h1);
    bus_read(fa(NW-1), v); check("R8 masked top read", v, 32'h0);
    check("R11 cfg ignores mask", {cfg_secure_dbg, cfg_jtag_off, cfg_boot}, model[NW-1]);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule